// File: doc/BRIEF.md
# Memory-Mapped 32-Input Interrupt Controller

This block merges up to 32 interrupt request lines into a single request to a processor. Every line is fixed at elaboration time as either edge-triggered or level-sensitive through a bit mask parameter. The lines pass through a two-stage synchronizer before they are captured into a status register. A pending set is formed from status AND enable, and a fixed priority encoder reports the lowest-numbered pending source as the vector.

Software reaches the block through a simple word-addressed port with valid, write, address and write-data inputs and a read-data output. Reads are combinational from the current register state and have no side effects. A two-bit master register has two jobs: bit 0 gates the processor request, and bit 1 turns hardware capture on or off. The enable bits can be written whole, or set and cleared bit by bit through write-only set and clear words. Status bits are cleared through a write-only acknowledge word. Software may load status directly only while hardware capture is off.

Top module: `irqc_top`

## Requirements
- R1: After reset, status, enable and master are zero, `irq_out` is low and the vector (word 6) reads 32'hFFFF_FFFF.
- R2: The master register (word 7) stores only bits [1:0] of a write and reads back zero in bits [31:2]; bit 0 enables the output and bit 1 enables hardware capture.
- R3: A level-sensitive source (mask bit 0) whose line is high sets its status bit on the third rising clock edge after the line rises, and keeps setting it on every edge while master bit 1 is set, so an acknowledge does not clear it while the line stays high.
- R4: An edge-triggered source (mask bit 1) sets its status bit only on a rising edge of its synchronized line that is seen while master bit 1 is set; a falling line never clears status, and an edge seen while capture is off is lost.
- R5: A write to the acknowledge word (word 3) clears every status bit whose written bit is 1 and leaves the other bits unchanged; the word reads as zero.
- R6: The enable word (word 2) is read/write; a write to set-enable (word 4) ORs the data into enable, and a write to clear-enable (word 5) clears the enable bits written as 1; words 4 and 5 read as zero.
- R7: The pending word (word 1) always reads status AND enable, and is read-only.
- R8: The vector word (word 6) reads the index of the lowest-numbered pending bit (bit 0 wins), or all ones when nothing is pending.
- R9: `irq_out` is high exactly when master bit 0 is set and pending is nonzero, in the same cycle in which the state changes.
- R10: A write to the status word (word 0) replaces status only while master bit 1 is clear; while it is set the write is ignored.
- R11: Reads of unmapped words (8 to 15) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, asynchronous |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check that the output request implies master bit 0 and a nonzero pending set. They also check that the vector names the lowest pending bit, that set and clear writes to enable take effect on the next edge, that an acknowledge with capture off leaves the written bits clear, that asserted level lines stay captured, and that no status bit appears while capture is off unless software loads status directly. Only the bench scenarios can show the three-edge latency through the synchronizer, that an edge seen with capture off is lost, that an ignored status write or an unmapped write leaves the read-back unchanged, and the exact value of every readable word.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the interrupt controller.
// Assumes word addressing with a 4-bit address; offsets 8..15 are unmapped.
package irqc_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STATUS  = 4'd0,
        OFS_PENDING = 4'd1,
        OFS_ENABLE  = 4'd2,
        OFS_ACK     = 4'd3,
        OFS_SET_EN  = 4'd4,
        OFS_CLR_EN  = 4'd5,
        OFS_VECTOR  = 4'd6,
        OFS_MASTER  = 4'd7
    } reg_ofs_e;

    // master register bit positions
    localparam int MST_OUT_BIT = 0;
    localparam int MST_CAP_BIT = 1;
endpackage

// File: rtl/irqc_sync.sv
// Module: multi-stage synchronizer for a bus of asynchronous request lines.
// Assumes each bit is independent (no bus coherency needed); resets to zero.
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // one flop stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else if (g == 0) chain[g] <= d_in;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/irqc_capture.sv
// Module: turns synchronized lines into per-source capture requests.
// Edge sources request on a rising level (current AND NOT previous);
// level sources request whenever the line is high. Capture gating is done
// by the caller.
module irqc_capture #(
    parameter int          N_SRC     = 32,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lvl,
    output logic [N_SRC-1:0] req
);
    logic [N_SRC-1:0] prev_q;

    // remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= lvl;
    end

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            if (EDGE_MASK[g]) begin : g_edge
                assign req[g] = lvl[g] & ~prev_q[g];
            end else begin : g_level
                assign req[g] = lvl[g];
            end
        end
    endgenerate
endmodule

// File: rtl/irqc_prio.sv
// Module: fixed-priority encoder, lowest index wins.
// Produces the winning index and a flag; index is zero when none pending.
module irqc_prio #(
    parameter int N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest set bit is assigned last
    always_comb begin
        idx = '0;
        for (int i = N_SRC-1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/irqc_top.sv
// Module: interrupt controller top. Holds status, enable and master registers,
// decodes the word-addressed access port and drives the processor request.
// Assumes N_SRC <= DATA_W; reads are side-effect free and combinational.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int               N_SRC       = 32,
    parameter int               DATA_W      = 32,
    parameter int               SYNC_STAGES = 2,
    parameter logic [N_SRC-1:0] EDGE_MASK   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] sync_lvl;
    logic [N_SRC-1:0] cap_req;
    logic [N_SRC-1:0] status_q, status_d;
    logic [N_SRC-1:0] enable_q, enable_d;
    logic [1:0]       master_q, master_d;
    logic [N_SRC-1:0] pending;
    logic             any_pend;
    logic [IDX_W-1:0] win_idx;
    logic [N_SRC-1:0] wdata_src;
    logic             wr_en;

    irqc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_in),
        .d_out (sync_lvl)
    );

    irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_lvl),
        .req   (cap_req)
    );

    assign pending = status_q & enable_q;

    irqc_prio #(.N_SRC(N_SRC)) u_prio (
        .pend (pending),
        .any  (any_pend),
        .idx  (win_idx)
    );

    assign wr_en     = bus_valid && bus_write;
    assign wdata_src = bus_wdata[N_SRC-1:0];

    // next-state of status: software write effects first, then hardware capture
    always_comb begin
        status_d = status_q;
        if (wr_en && bus_addr == OFS_ACK)
            status_d = status_q & ~wdata_src;
        if (wr_en && bus_addr == OFS_STATUS && !master_q[MST_CAP_BIT])
            status_d = wdata_src;
        if (master_q[MST_CAP_BIT])
            status_d = status_d | cap_req;
    end

    // next-state of enable: direct, set-only and clear-only writes
    always_comb begin
        enable_d = enable_q;
        if (wr_en) begin
            case (bus_addr)
                OFS_ENABLE: enable_d = wdata_src;
                OFS_SET_EN: enable_d = enable_q | wdata_src;
                OFS_CLR_EN: enable_d = enable_q & ~wdata_src;
                default:    enable_d = enable_q;
            endcase
        end
    end

    // next-state of master: only the two low bits are kept
    always_comb begin
        master_d = master_q;
        if (wr_en && bus_addr == OFS_MASTER) master_d = bus_wdata[1:0];
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            master_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
            master_q <= master_d;
        end
    end

    // read mux; write-only and unmapped words read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STATUS:  bus_rdata = DATA_W'(status_q);
            OFS_PENDING: bus_rdata = DATA_W'(pending);
            OFS_ENABLE:  bus_rdata = DATA_W'(enable_q);
            OFS_VECTOR:  bus_rdata = any_pend ? DATA_W'(win_idx) : '1;
            OFS_MASTER:  bus_rdata = DATA_W'(master_q);
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_out = master_q[MST_OUT_BIT] && any_pend;
endmodule

// File: rtl/irqc_checker.sv
// Module: assertion checker for irqc_top, attached by bind below.
// Observes ports and the internal state registers of the top.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int               N_SRC     = 32,
    parameter int               DATA_W    = 32,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_out,
    input logic [N_SRC-1:0]  status_q,
    input logic [N_SRC-1:0]  enable_q,
    input logic [1:0]        master_q,
    input logic [N_SRC-1:0]  sync_lvl,
    input logic              any_pend,
    input logic [IDX_W-1:0]  win_idx
);
    logic [N_SRC-1:0] pend_c;
    logic [N_SRC-1:0] below_mask;
    logic             wr_ack, wr_set, wr_clr, wr_stat;
    assign pend_c     = status_q & enable_q;
    assign below_mask = (N_SRC'(1) << win_idx) - N_SRC'(1);
    assign wr_ack  = bus_valid && bus_write && bus_addr == OFS_ACK;
    assign wr_set  = bus_valid && bus_write && bus_addr == OFS_SET_EN;
    assign wr_clr  = bus_valid && bus_write && bus_addr == OFS_CLR_EN;
    assign wr_stat = bus_valid && bus_write && bus_addr == OFS_STATUS;

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (master_q[0] && pend_c != '0));

    p_vec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |-> (pend_c[win_idx] && (pend_c & below_mask) == '0));

    p_set_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    p_clr_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !master_q[1]) |=> ((status_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        master_q[1] |=> ((status_q & $past(sync_lvl & ~EDGE_MASK)) == $past(sync_lvl & ~EDGE_MASK)));

    p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_q[1] && !wr_stat) |=> ((status_q & ~$past(status_q)) == '0));
endmodule

bind irqc_top irqc_checker #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .EDGE_MASK(EDGE_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
    .status_q(status_q), .enable_q(enable_q), .master_q(master_q),
    .sync_lvl(sync_lvl), .any_pend(any_pend), .win_idx(win_idx)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] EDGES      = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench-side model state
    logic [31:0] m_s1, m_s2, m_prev, m_stat, m_en;
    logic [1:0]  m_mst;

    irqc_top #(.EDGE_MASK(EDGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_vec(input logic [31:0] p);
        logic [31:0] v = 32'hFFFF_FFFF;
        for (int i = 31; i >= 0; i--) if (p[i]) v = i;
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return m_stat;
            4'd1: return m_stat & m_en;
            4'd2: return m_en;
            4'd6: return exp_vec(m_stat & m_en);
            4'd7: return {30'd0, m_mst};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R10";
            4'd1: return "R7";
            4'd2, 4'd4, 4'd5: return "R6";
            4'd3: return "R5";
            4'd6: return "R8";
            4'd7: return "R2";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0; m_en = '0; m_mst = '0;
    endtask

    // advance the model by one clock edge with the given inputs
    task automatic model_step(input logic [31:0] irq, input logic v, input logic w,
                              input logic [3:0] a, input logic [31:0] d);
        logic [31:0] st, en, req;
        logic [1:0]  ms;
        st = m_stat; en = m_en; ms = m_mst;
        req = (m_s2 & ~EDGES) | (m_s2 & ~m_prev & EDGES);
        if (v && w) begin
            case (a)
                4'd0: if (!m_mst[1]) st = d;
                4'd2: en = d;
                4'd3: st = m_stat & ~d;
                4'd4: en = m_en | d;
                4'd5: en = m_en & ~d;
                4'd7: ms = d[1:0];
                default: ;
            endcase
        end
        if (m_mst[1]) st = st | req;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
        m_stat = st; m_en = en; m_mst = ms;
    endtask

    // one bus cycle: drive, check read data and output, then clock
    task automatic cyc(input logic [31:0] irq, input logic v, input logic w,
                       input logic [3:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        irq_in = irq; bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        #1;
        check(tag, bus_rdata, exp_read(a));
        check("R9", {31'd0, irq_out}, {31'd0, m_mst[0] && ((m_stat & m_en) != 0)});
        model_step(irq, v, w, a, d);
        @(posedge clk);
    endtask

    task automatic rd(input logic [31:0] irq, input logic [3:0] a, input string tag);
        cyc(irq, 1'b1, 1'b0, a, 32'd0, tag);
    endtask

    task automatic wr(input logic [31:0] irq, input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(irq, 1'b1, 1'b1, a, d, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] irq;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd('0, 4'd6, "R1");
        rd('0, 4'd7, "R1");
        rd('0, 4'd0, "R1");
        rd('0, 4'd2, "R1");

        // R2 master keeps two bits
        wr('0, 4'd7, 32'hFFFF_FFFF, "R2");
        rd('0, 4'd7, "R2");

        // R6 enable set/clear and read-only check of write-only words
        wr('0, 4'd4, 32'hFFFF_FFFF, "R6");
        wr('0, 4'd5, 32'h0000_00F0, "R6");
        rd('0, 4'd2, "R6");
        rd('0, 4'd4, "R6");

        // R3 level source bit 3: appears after sync, survives ack while high
        irq = 32'h0000_0008;
        for (int i = 0; i < 4; i++) rd(irq, 4'd0, "R3");
        wr(irq, 4'd3, 32'h0000_0008, "R5");
        rd(irq, 4'd0, "R3");
        irq = '0;
        for (int i = 0; i < 3; i++) rd(irq, 4'd0, "R3");
        wr(irq, 4'd3, 32'h0000_0008, "R5");
        rd(irq, 4'd0, "R5");

        // R4 edge source bit 20: set on rise, kept after fall
        irq = 32'h0010_0000;
        for (int i = 0; i < 4; i++) rd(irq, 4'd0, "R4");
        irq = '0;
        for (int i = 0; i < 4; i++) rd(irq, 4'd0, "R4");
        rd(irq, 4'd6, "R8");
        wr(irq, 4'd3, 32'h0010_0000, "R5");

        // R4 edge lost while capture off
        wr(irq, 4'd7, 32'd1, "R2");
        irq = 32'h0020_0000;
        for (int i = 0; i < 4; i++) rd(irq, 4'd0, "R4");
        wr(irq, 4'd7, 32'd3, "R2");
        for (int i = 0; i < 3; i++) rd(irq, 4'd0, "R4");
        irq = '0;
        wr(irq, 4'd7, 32'd1, "R2");

        // R10 direct status write with capture off, R7/R8/R9 views
        wr(irq, 4'd0, 32'h0000_0005, "R10");
        rd(irq, 4'd0, "R10");
        rd(irq, 4'd1, "R7");
        rd(irq, 4'd6, "R8");
        wr(irq, 4'd5, 32'h0000_0001, "R6");
        rd(irq, 4'd6, "R8");
        wr(irq, 4'd7, 32'd3, "R2");
        wr(irq, 4'd0, 32'h0000_0080, "R10");
        rd(irq, 4'd0, "R10");

        // R11 unmapped access
        wr(irq, 4'd12, 32'hFFFF_FFFF, "R11");
        rd(irq, 4'd12, "R11");
        rd(irq, 4'd2, "R11");
        rd(irq, 4'd3, "R11");

        // random mix: sparse line toggles, random accesses
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] a;
            logic       v, w;
            if ($urandom_range(0, 3) == 0) irq = irq ^ (32'd1 << $urandom_range(0, 31));
            a = 4'($urandom_range(0, 15));
            v = ($urandom_range(0, 1) == 1);
            w = v && ($urandom_range(0, 2) == 0);
            cyc(irq, v, w, a, $urandom, tag_of(a));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule